// File: doc/BRIEF.md
# Two-Port Address Window Router

This block sits on a processor-side request path. It forwards each request to one of two downstream ports. A programmable page window chooses the port: a request whose address page lies inside the window goes to the memory port (port 1). Every other request goes to the interconnect port (port 0). The window is described by a low page and a high page, each counted in 1 MB units, so only the upper twelve address bits take part in the decision. The window is shared by every requester that drives this path.

Software programs the two page bounds through a small write-only register interface. A bound write is held off while any transaction is still in flight. While the write waits, new requests are refused, so the in-flight traffic drains and the new window never splits a transaction. On the return side, a small in-order record of the chosen ports sends each response back from the correct port. A response that arrives early on the other port waits its turn.

Top module: `addr_window_router`

## Requirements
- R1: A request goes to at most one port. It is accepted (`up_ready_o` high) only when the chosen port is ready, fewer than OUTSTANDING transactions are in flight, and no bound write is pending. The chosen port's request valid stays high while that port is not ready.
- R2: A request whose page `up_addr_i[31:20]` satisfies low ≤ page < high goes to the memory port (`mem_*`, port 1).
- R3: A request whose page lies outside the window goes to the interconnect port (`ic_*`, port 0). This includes a page equal to the high bound.
- R4: When low ≥ high the window is empty and every request goes to the interconnect port. After reset both bounds are 0, so all traffic goes to the interconnect port.
- R5: Only address bits 31:20 affect the choice. The full address, the write flag and the write data reach the chosen port unchanged in the same cycle.
- R6: Every request produces exactly one response. Responses return upstream in request order, each taken from the port its request went to. The other port's `*_rsp_ready_o` stays low, and no upstream response appears while nothing is in flight.
- R7: A bound write (`cfg_wr_sel_i` 0 = low bound, 1 = high bound, value = page number) is accepted only when no transaction is in flight. While it waits, new requests are refused. The new bound steers requests from the cycle after the write is accepted.
- R8: With OUTSTANDING transactions in flight (default 4), new requests are refused until a response completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_valid_i | input | 1 | Upstream request valid |
| up_ready_o | output | 1 | Upstream request accepted |
| up_addr_i | input | 32 | Request address |
| up_we_i | input | 1 | Request is a write |
| up_wdata_i | input | 32 | Write data |
| up_rsp_valid_o | output | 1 | Upstream response valid |
| up_rsp_ready_i | input | 1 | Upstream response taken |
| up_rsp_rdata_o | output | 32 | Upstream response data |
| cfg_wr_valid_i | input | 1 | Bound write request |
| cfg_wr_ready_o | output | 1 | Bound write accepted |
| cfg_wr_sel_i | input | 1 | 0 = low bound, 1 = high bound |
| cfg_wr_value_i | input | 12 | Bound value in 1 MB pages |
| ic_req_valid_o | output | 1 | Interconnect port request valid |
| ic_req_ready_i | input | 1 | Interconnect port ready |
| ic_req_addr_o | output | 32 | Interconnect port address |
| ic_req_we_o | output | 1 | Interconnect port write flag |
| ic_req_wdata_o | output | 32 | Interconnect port write data |
| ic_rsp_valid_i | input | 1 | Interconnect port response valid |
| ic_rsp_ready_o | output | 1 | Interconnect port response taken |
| ic_rsp_rdata_i | input | 32 | Interconnect port response data |
| mem_req_valid_o | output | 1 | Memory port request valid |
| mem_req_ready_i | input | 1 | Memory port ready |
| mem_req_addr_o | output | 32 | Memory port address |
| mem_req_we_o | output | 1 | Memory port write flag |
| mem_req_wdata_o | output | 32 | Memory port write data |
| mem_rsp_valid_i | input | 1 | Memory port response valid |
| mem_rsp_ready_o | output | 1 | Memory port response taken |
| mem_rsp_rdata_i | input | 32 | Memory port response data |

## Verification
Routing and acceptance are combinational, so the port choice is due in the same cycle as the upstream request. The bench drives inputs just after a rising edge and samples at the next falling edge. A response also passes through without a register: it is due in the cycle the port model raises it, and the scoreboard monitor compares it at the falling edge before the transfer edge. A bound write changes routing one edge after it is accepted, so the requests that follow it are issued only after that edge.

// File: rtl/awr_pkg.sv
package awr_pkg;
  typedef enum logic {
    DEST_IC  = 1'b0,
    DEST_MEM = 1'b1
  } dest_e;
endpackage

// File: rtl/awr_window_regs.sv
module awr_window_regs #(
  parameter int unsigned PAGE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [PAGE_W-1:0] wr_value_i,
  output logic [PAGE_W-1:0] lo_o,
  output logic [PAGE_W-1:0] hi_o
);
  logic [PAGE_W-1:0] lo_q, lo_n, hi_q, hi_n;

  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    if (wr_en_i) begin
      if (wr_sel_i) hi_n = wr_value_i;
      else          lo_n = wr_value_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_en_i) begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/awr_page_match.sv
module awr_page_match #(
  parameter int unsigned PAGE_W = 12
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PAGE_W-1:0] lo_i,
  input  logic [PAGE_W-1:0] hi_i,
  output logic              hit_o
);
  logic above_lo, below_hi;

  always_comb begin
    above_lo = (page_i >= lo_i);
    below_hi = (page_i <  hi_i);
    hit_o    = above_lo && below_hi;
  end
endmodule

// File: rtl/awr_order_fifo.sv
module awr_order_fifo
  import awr_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  dest_e push_dest_i,
  input  logic  pop_i,
  output dest_e head_o,
  output logic  empty_o,
  output logic  full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  dest_e              slot_q [DEPTH];
  logic [PTR_W-1:0]   wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (push_i) wr_n = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop_i)  rd_n = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({push_i, pop_i})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) slot_q[wr_q] <= push_dest_i;
  end

  assign head_o  = slot_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R6
endmodule

// File: rtl/addr_window_router.sv
module addr_window_router
  import awr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned PAGE_LSB    = 20,
  parameter int unsigned OUTSTANDING = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         up_valid_i,
  output logic                         up_ready_o,
  input  logic [ADDR_W-1:0]            up_addr_i,
  input  logic                         up_we_i,
  input  logic [DATA_W-1:0]            up_wdata_i,
  output logic                         up_rsp_valid_o,
  input  logic                         up_rsp_ready_i,
  output logic [DATA_W-1:0]            up_rsp_rdata_o,
  input  logic                         cfg_wr_valid_i,
  output logic                         cfg_wr_ready_o,
  input  logic                         cfg_wr_sel_i,
  input  logic [ADDR_W-PAGE_LSB-1:0]   cfg_wr_value_i,
  output logic                         ic_req_valid_o,
  input  logic                         ic_req_ready_i,
  output logic [ADDR_W-1:0]            ic_req_addr_o,
  output logic                         ic_req_we_o,
  output logic [DATA_W-1:0]            ic_req_wdata_o,
  input  logic                         ic_rsp_valid_i,
  output logic                         ic_rsp_ready_o,
  input  logic [DATA_W-1:0]            ic_rsp_rdata_i,
  output logic                         mem_req_valid_o,
  input  logic                         mem_req_ready_i,
  output logic [ADDR_W-1:0]            mem_req_addr_o,
  output logic                         mem_req_we_o,
  output logic [DATA_W-1:0]            mem_req_wdata_o,
  input  logic                         mem_rsp_valid_i,
  output logic                         mem_rsp_ready_o,
  input  logic [DATA_W-1:0]            mem_rsp_rdata_i
);
  localparam int unsigned PAGE_W = ADDR_W - PAGE_LSB;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  logic [PAGE_W-1:0] page, win_lo, win_hi;
  logic              hit, cfg_fire;
  dest_e             req_dest, head_dest;
  logic              fifo_empty, fifo_full, push, pop;
  logic              dest_ready, req_open;

  assign page     = up_addr_i[ADDR_W-1:PAGE_LSB];
  assign cfg_fire = cfg_wr_valid_i && cfg_wr_ready_o;

  awr_window_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .wr_en_i    (cfg_fire),
    .wr_sel_i   (cfg_wr_sel_i),
    .wr_value_i (cfg_wr_value_i),
    .lo_o       (win_lo),
    .hi_o       (win_hi)
  );

  awr_page_match #(.PAGE_W(PAGE_W)) u_match (
    .page_i (page),
    .lo_i   (win_lo),
    .hi_i   (win_hi),
    .hit_o  (hit)
  );

  awr_order_fifo #(.DEPTH(OUTSTANDING)) u_order (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .push_i      (push),
    .push_dest_i (req_dest),
    .pop_i       (pop),
    .head_o      (head_dest),
    .empty_o     (fifo_empty),
    .full_o      (fifo_full)
  );

  // request side
  always_comb begin
    req_dest        = hit ? DEST_MEM : DEST_IC;
    dest_ready      = (req_dest == DEST_MEM) ? mem_req_ready_i : ic_req_ready_i;
    req_open        = up_valid_i && !fifo_full && !cfg_wr_valid_i;
    ic_req_valid_o  = req_open && (req_dest == DEST_IC);
    mem_req_valid_o = req_open && (req_dest == DEST_MEM);
    up_ready_o      = !fifo_full && !cfg_wr_valid_i && dest_ready;
    push            = up_valid_i && up_ready_o;
  end

  assign ic_req_addr_o   = up_addr_i;
  assign ic_req_we_o     = up_we_i;
  assign ic_req_wdata_o  = up_wdata_i;
  assign mem_req_addr_o  = up_addr_i;
  assign mem_req_we_o    = up_we_i;
  assign mem_req_wdata_o = up_wdata_i;

  // bound writes wait for an idle path
  assign cfg_wr_ready_o = fifo_empty;

  // response side
  always_comb begin
    up_rsp_valid_o  = !fifo_empty &&
                      ((head_dest == DEST_MEM) ? mem_rsp_valid_i : ic_rsp_valid_i);
    up_rsp_rdata_o  = (head_dest == DEST_MEM) ? mem_rsp_rdata_i : ic_rsp_rdata_i;
    ic_rsp_ready_o  = !fifo_empty && (head_dest == DEST_IC)  && up_rsp_ready_i;
    mem_rsp_ready_o = !fifo_empty && (head_dest == DEST_MEM) && up_rsp_ready_i;
    pop             = up_rsp_valid_o && up_rsp_ready_i;
  end

  AST_MEM_NEEDS_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    mem_req_valid_o |-> (win_lo < win_hi)); // R4
  AST_HIGH_EXCLUDED: assert property (@(posedge clk_i) disable iff (!rst_n)
    mem_req_valid_o |-> (page != win_hi)); // R3
  AST_WINDOW_FROZEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n)
    !fifo_empty |=> ($stable(win_lo) && $stable(win_hi))); // R7
  AST_ONE_RSP_READY: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({ic_rsp_ready_o, mem_rsp_ready_o})); // R6
endmodule

// File: tb/test_addr_window_router.sv
`timescale 1ns/1ps
module test_addr_window_router;
  localparam logic [31:0] K_IC  = 32'h0F0F_0000;
  localparam logic [31:0] K_MEM = 32'h00F0_F0F0;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        up_valid, up_ready, up_we, up_rsp_valid, up_rsp_ready;
  logic [31:0] up_addr, up_wdata, up_rsp_rdata;
  logic        cfg_valid, cfg_ready, cfg_sel;
  logic [11:0] cfg_value;
  logic        ic_req_valid, ic_req_ready, ic_req_we, ic_rsp_valid, ic_rsp_ready;
  logic [31:0] ic_req_addr, ic_req_wdata, ic_rsp_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit rst_done = 1'b0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  addr_window_router i_addr_window_router (
    .clk_i(clk), .rst_ni(rst_ni),
    .up_valid_i(up_valid), .up_ready_o(up_ready), .up_addr_i(up_addr),
    .up_we_i(up_we), .up_wdata_i(up_wdata),
    .up_rsp_valid_o(up_rsp_valid), .up_rsp_ready_i(up_rsp_ready), .up_rsp_rdata_o(up_rsp_rdata),
    .cfg_wr_valid_i(cfg_valid), .cfg_wr_ready_o(cfg_ready), .cfg_wr_sel_i(cfg_sel),
    .cfg_wr_value_i(cfg_value),
    .ic_req_valid_o(ic_req_valid), .ic_req_ready_i(ic_req_ready), .ic_req_addr_o(ic_req_addr),
    .ic_req_we_o(ic_req_we), .ic_req_wdata_o(ic_req_wdata),
    .ic_rsp_valid_i(ic_rsp_valid), .ic_rsp_ready_o(ic_rsp_ready), .ic_rsp_rdata_i(ic_rsp_rdata),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready), .mem_req_addr_o(mem_req_addr),
    .mem_req_we_o(mem_req_we), .mem_req_wdata_o(mem_req_wdata),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_ready_o(mem_rsp_ready), .mem_rsp_rdata_i(mem_rsp_rdata)
  );

  // downstream port models: answer with the request address folded with a port key
  logic [31:0] ic_mem_q [16];
  logic [31:0] mm_mem_q [16];
  logic [7:0]  ic_w = '0, ic_r = '0, mm_w = '0, mm_r = '0;
  logic        ic_gate = 1'b1, mm_gate = 1'b1;

  always @(posedge clk) begin
    if (ic_req_valid && ic_req_ready) begin ic_mem_q[ic_w[3:0]] <= ic_req_addr; ic_w <= ic_w + 8'd1; end
    if (ic_rsp_valid && ic_rsp_ready) ic_r <= ic_r + 8'd1;
    if (mem_req_valid && mem_req_ready) begin mm_mem_q[mm_w[3:0]] <= mem_req_addr; mm_w <= mm_w + 8'd1; end
    if (mem_rsp_valid && mem_rsp_ready) mm_r <= mm_r + 8'd1;
  end
  assign ic_rsp_valid  = (ic_w != ic_r) && ic_gate;
  assign ic_rsp_rdata  = ic_mem_q[ic_r[3:0]] ^ K_IC;
  assign mem_rsp_valid = (mm_w != mm_r) && mm_gate;
  assign mem_rsp_rdata = mm_mem_q[mm_r[3:0]] ^ K_MEM;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_done && up_rsp_valid && up_rsp_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 response with nothing in flight", up_rsp_rdata, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(up_rsp_rdata == e, "R6 response order and source port", up_rsp_rdata, e);
      end
    end
  end

  // driver: issue one request and check its port
  task automatic send(input logic [31:0] a, input bit to_mem, input string req);
    up_addr = a; up_wdata = ~a; up_we = a[2]; up_valid = 1'b1;
    do @(negedge clk); while (!up_ready);
    chk({mem_req_valid, ic_req_valid} == {to_mem, !to_mem}, req,
        {30'b0, mem_req_valid, ic_req_valid}, {30'b0, to_mem, !to_mem});
    if (to_mem) chk(mem_req_addr == a && mem_req_wdata == ~a && mem_req_we == a[2],
                    "R5 fields to memory port", mem_req_addr, a);
    else        chk(ic_req_addr == a && ic_req_wdata == ~a && ic_req_we == a[2],
                    "R5 fields to interconnect port", ic_req_addr, a);
    exp_q.push_back(a ^ (to_mem ? K_MEM : K_IC));
    @(posedge clk); #1 up_valid = 1'b0;
  endtask

  task automatic cfg_write(input bit sel, input logic [11:0] v);
    cfg_sel = sel; cfg_value = v; cfg_valid = 1'b1;
    do @(negedge clk); while (!cfg_ready);
    @(posedge clk); #1 cfg_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all responses returned", exp_q.size(), 0);
    @(posedge clk); #1;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; up_valid = 1'b0; up_addr = '0; up_we = 1'b0; up_wdata = '0;
    up_rsp_ready = 1'b1; cfg_valid = 1'b0; cfg_sel = 1'b0; cfg_value = '0;
    ic_req_ready = 1'b1; mem_req_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_done = 1'b1;

    // reset state
    @(negedge clk);
    chk(!ic_req_valid && !mem_req_valid, "R1 no request at reset", {30'b0, mem_req_valid, ic_req_valid}, 0);
    chk(!up_rsp_valid, "R6 no response at reset", up_rsp_valid, 0);
    chk(cfg_ready, "R7 bound write ready when idle", cfg_ready, 1);
    @(posedge clk); #1;

    // R4: empty window after reset
    send(32'h0000_0000, 1'b0, "R4 reset window empty, page 0");
    send(32'hFFFF_F000, 1'b0, "R4 reset window empty, top page");

    // window 0x400..0x800
    cfg_write(1'b0, 12'h400); cfg_write(1'b1, 12'h800);
    send(32'h3FFF_FFFC, 1'b0, "R3 just below low bound");
    send(32'h4000_0000, 1'b1, "R2 at low bound");
    send(32'h7FFF_FFFC, 1'b1, "R2 last page inside");
    send(32'h8000_0000, 1'b0, "R3 page equal to high bound");
    send(32'h4ABC_DEF4, 1'b1, "R5 low bits ignored inside");
    send(32'h400F_FFFC, 1'b1, "R5 low bits all ones inside");
    drain();

    // lower 3 GB to memory
    cfg_write(1'b0, 12'h000); cfg_write(1'b1, 12'hC00);
    send(32'h0000_0000, 1'b1, "R2 3GB window page 0");
    send(32'hBFFF_FFFC, 1'b1, "R2 3GB window last page");
    send(32'hC000_0000, 1'b0, "R3 3GB window high bound");
    send(32'hFFFF_FFFC, 1'b0, "R3 3GB window above");

    // empty windows
    cfg_write(1'b0, 12'h800); cfg_write(1'b1, 12'h800);
    send(32'h8000_0000, 1'b0, "R4 low equal high");
    cfg_write(1'b0, 12'h900); cfg_write(1'b1, 12'h100);
    send(32'h0000_0000, 1'b0, "R4 low above high, page 0");
    send(32'h5000_0000, 1'b0, "R4 low above high, middle");
    send(32'h9000_0000, 1'b0, "R4 low above high, at low");
    drain();

    // R6: ordering across ports
    cfg_write(1'b0, 12'h400); cfg_write(1'b1, 12'h800);
    ic_gate = 1'b0;
    send(32'h1000_0000, 1'b0, "R6 first request to interconnect");
    send(32'h4000_0010, 1'b1, "R6 second request to memory");
    repeat (2) @(negedge clk);
    chk(!up_rsp_valid, "R6 early memory response held", up_rsp_valid, 0);
    chk(mem_rsp_valid && !mem_rsp_ready, "R6 memory rsp ready low while waiting",
        {30'b0, mem_rsp_valid, mem_rsp_ready}, 32'h2);
    @(posedge clk); #1 ic_gate = 1'b1;
    drain();

    // R7: bound write waits for idle and blocks requests
    ic_gate = 1'b0;
    send(32'h1000_0000, 1'b0, "R7 request before bound write");
    cfg_sel = 1'b1; cfg_value = 12'h500; cfg_valid = 1'b1;
    up_addr = 32'h4000_0000; up_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cfg_ready, "R7 bound write held while busy", cfg_ready, 0);
    chk(!up_ready && !mem_req_valid && !ic_req_valid, "R7 requests refused while write pending",
        {29'b0, up_ready, mem_req_valid, ic_req_valid}, 0);
    @(posedge clk); #1 up_valid = 1'b0; ic_gate = 1'b1;
    cfg_write(1'b1, 12'h500);
    drain();
    send(32'h4FFF_FFFC, 1'b1, "R7 new high bound, inside");
    send(32'h5000_0000, 1'b0, "R7 new high bound now excluded");
    drain();

    // R8: in-flight limit
    ic_gate = 1'b0;
    for (int i = 0; i < 4; i++) send(32'h2000_0000 + 32'(i * 4), 1'b0, "R8 fill in-flight record");
    up_addr = 32'h2000_0100; up_valid = 1'b1;
    @(negedge clk);
    chk(!up_ready && !ic_req_valid, "R8 refused at in-flight limit",
        {30'b0, up_ready, ic_req_valid}, 0);
    @(posedge clk); #1 up_valid = 1'b0; ic_gate = 1'b1;
    drain();
    send(32'h2000_0100, 1'b0, "R8 accepted after drain");

    // R1: chosen port not ready
    mem_req_ready = 1'b0;
    up_addr = 32'h4000_0000; up_valid = 1'b1;
    @(negedge clk);
    chk(!up_ready && mem_req_valid && !ic_req_valid, "R1 stall on busy memory port",
        {29'b0, up_ready, mem_req_valid, ic_req_valid}, 32'h2);
    @(posedge clk); #1 mem_req_ready = 1'b1;
    send(32'h4000_0000, 1'b1, "R1 accepted once port ready");
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule